// File: doc/BRIEF.md
# Ripple-Chain Leading Zero Counter

This block counts how many equal bits open an N-bit operand before the first bit of the opposite value, in a single combinational path. The operand first passes through a conditioning stage. That stage can reverse the bit order, which turns a leading count into a trailing count. It can also invert every bit, so the block counts ones instead of zeros. The conditioned word is then extended with a constant one in a guard slot below its lowest bit.

A column of identical one-bit cells scans the extended word from its top. A "found" flag travels down the column, and each cell marks its own position when it holds a one that no cell above it has already claimed. The result is a one-hot vector with exactly one bit set. An OR-plane encoder turns the index of that bit into the binary count. The guard slot means an operand with no qualifying bit still gives a valid position, and that position reads as N.

The block has no clock and no state. It is meant to sit inside a larger datapath stage, with registers supplied by the surrounding logic.

Top module: `zero_run_counter`

## Requirements
- R1: The operand width is the parameter N, with a default of 8. The count output is $clog2(N+1) bits wide, which is 4 bits at N=8.
- R2: With count_trailing=0 and count_ones=0, count equals the number of consecutive 0 bits starting at operand[N-1] and moving toward bit 0. An all-zero operand gives N.
- R3: The internal one-hot vector has exactly one bit set for every operand and mode, and count never exceeds N.
- R4: At N=8 in the default mode, 8'b00000000 gives 8, 8'b00111010 gives 2, 8'b10101000 gives 0 and 8'b00111011 gives 2.
- R5: With count_trailing=1 and count_ones=0, count equals the number of consecutive 0 bits starting at operand[0] and moving upward. An all-zero operand gives N.
- R6: With count_trailing=0 and count_ones=1, count equals the number of consecutive 1 bits starting at operand[N-1]. An all-ones operand gives N.
- R7: With both mode inputs at 1, count equals the number of consecutive 1 bits starting at operand[0]. An all-ones operand gives N.
- R8: count is a purely combinational function of operand, count_trailing and count_ones. It settles within the same clock period in which any of these inputs change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | N | Word to be scanned |
| count_trailing | input | 1 | 1: scan from bit 0 upward; 0: scan from bit N-1 downward |
| count_ones | input | 1 | 1: count ones; 0: count zeros |
| count | output | $clog2(N+1) | Length of the run, from 0 to N |

## Verification
The bench builds the block at the default N=8. At that width all 256 operands can be applied in each of the four mode combinations, so every one-hot position and every guard case is reached, including the all-zero and all-ones words that select the guard slot. Directed checks cover the worked example values and the single-bit operands at each end of the word. Those cases cover both the shortest and the longest ripple through the cell column.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  // Width of a count that can hold the values 0..n inclusive.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lzc_cond.sv
// Operand conditioning: optional bit reversal (trailing scan) and optional
// inversion (count ones), so the chain always looks for the first 1 from the top.
module lzc_cond #(
  parameter int N = 8
) (
  input  logic [N-1:0] raw,
  input  logic         reverse,
  input  logic         invert,
  output logic [N-1:0] shaped
);
  logic [N-1:0] flipped;
  logic [N-1:0] ordered;

  for (genvar i = 0; i < N; i++) begin : g_rev
    assign flipped[i] = raw[N-1-i];
  end

  assign ordered = reverse ? flipped : raw;
  assign shaped  = invert ? ~ordered : ordered;
endmodule

// File: rtl/lzc_cell.sv
// One slot of the ripple column.
module lzc_cell (
  input  logic data_bit,
  input  logic found_in,
  output logic hot,
  output logic found_out
);
  assign hot       = data_bit & ~found_in;
  assign found_out = found_in | data_bit;
endmodule

// File: rtl/lzc_chain.sv
// Ripple column: N cells scanning from the MSB plus a guard slot that is
// always 1. hot[k] marks the k-th position counted from the top.
module lzc_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] word,
  output logic [N:0]   hot
);
  logic [N:0] found;

  assign found[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_cell
    lzc_cell u_cell (
      .data_bit  (word[N-1-k]),
      .found_in  (found[k]),
      .hot       (hot[k]),
      .found_out (found[k+1])
    );
  end

  // Guard slot: its data bit is a constant one.
  assign hot[N] = ~found[N];
endmodule

// File: rtl/lzc_encoder.sv
// OR-plane encoder from an (N+1)-wide one-hot vector to a binary index.
module lzc_encoder #(
  parameter int N  = 8,
  parameter int CW = lzc_pkg::count_width(N)
) (
  input  logic [N:0]    hot,
  output logic [CW-1:0] index
);
  for (genvar b = 0; b < CW; b++) begin : g_bit
    logic [N:0] sel;
    for (genvar k = 0; k <= N; k++) begin : g_pos
      if (((k >> b) & 1) == 1) begin : g_on
        assign sel[k] = hot[k];
      end else begin : g_off
        assign sel[k] = 1'b0;
      end
    end
    assign index[b] = |sel;
  end
endmodule

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
  parameter int N  = 8,
  parameter int CW = lzc_pkg::count_width(N)
) (
  input  logic [N-1:0]  operand,
  input  logic          count_trailing,
  input  logic          count_ones,
  output logic [CW-1:0] count
);
  logic [N-1:0] shaped;
  logic [N:0]   hot;

  lzc_cond #(.N(N)) u_cond (
    .raw     (operand),
    .reverse (count_trailing),
    .invert  (count_ones),
    .shaped  (shaped)
  );

  lzc_chain #(.N(N)) u_chain (
    .word (shaped),
    .hot  (hot)
  );

  lzc_encoder #(.N(N), .CW(CW)) u_enc (
    .hot   (hot),
    .index (count)
  );
endmodule

// File: rtl/lzc_checker.sv
module lzc_checker #(
  parameter int N  = 8,
  parameter int CW = lzc_pkg::count_width(N)
) (
  input logic [N-1:0]  operand,
  input logic          count_trailing,
  input logic          count_ones,
  input logic [N:0]    hot,
  input logic [CW-1:0] count
);
  always_comb begin
    if (!$isunknown({operand, count_trailing, count_ones})) begin
      AST_SINGLE_HOT: assert ($onehot(hot)) else $error("hot not one-hot"); // R3
      AST_COUNT_BOUND: assert (count <= CW'(N)) else $error("count above N"); // R3
      if (!count_ones && operand == '0)
        AST_ZERO_WORD: assert (count == CW'(N)) else $error("zero word"); // R2
      if (count_ones && operand == '1)
        AST_ONES_WORD: assert (count == CW'(N)) else $error("ones word"); // R6
      if (!count_trailing && !count_ones && operand[N-1])
        AST_TOP_SET: assert (count == '0) else $error("top bit set"); // R2
      if (count_trailing && !count_ones && operand[0])
        AST_LOW_SET: assert (count == '0) else $error("low bit set"); // R5
      if (count_trailing && count_ones && !operand[0])
        AST_LOW_CLEAR: assert (count == '0) else $error("low bit clear"); // R7
    end
  end
endmodule

bind zero_run_counter lzc_checker #(.N(N), .CW(CW)) u_lzc_chk (
  .operand        (operand),
  .count_trailing (count_trailing),
  .count_ones     (count_ones),
  .hot            (hot),
  .count          (count)
);

// File: tb/tb_zero_run_counter.sv
module tb_zero_run_counter;
  localparam int N  = 8;
  localparam int CW = lzc_pkg::count_width(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  operand = '0;
  logic          count_trailing = 1'b0;
  logic          count_ones = 1'b0;
  logic [CW-1:0] count;
  int            n_vec = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  zero_run_counter #(.N(N)) dut (
    .operand        (operand),
    .count_trailing (count_trailing),
    .count_ones     (count_ones),
    .count          (count)
  );

  function automatic int ref_count(input logic [N-1:0] v, input bit trail, input bit ones);
    int c = 0;
    for (int i = 0; i < N; i++) begin
      int pos = trail ? i : N - 1 - i;
      if (v[pos] == ones) c++;
      else break;
    end
    return c;
  endfunction

  task automatic check(input logic [N-1:0] v, input bit trail, input bit ones,
                       input int expv, input string req);
    @(posedge clk);
    operand        <= v;
    count_trailing <= trail;
    count_ones     <= ones;
    @(negedge clk);
    n_vec++;
    if (int'(count) != expv) begin
      n_bad++;
      $display("FAIL %s op=%b t=%0b o=%0b actual=%0d expected=%0d",
               req, v, trail, ones, count, expv);
    end
  endtask

  task automatic t_width();
    n_vec++;
    if ($bits(count) != 4) begin
      n_bad++;
      $display("FAIL R1 count width actual=%0d expected=4", $bits(count));
    end
  endtask

  task automatic t_examples();
    check(8'b00000000, 0, 0, 8, "R4");
    check(8'b00111010, 0, 0, 2, "R4");
    check(8'b10101000, 0, 0, 0, "R4");
    check(8'b00111011, 0, 0, 2, "R4");
  endtask

  task automatic t_sweep(input bit trail, input bit ones, input string req);
    for (int v = 0; v < (1 << N); v++)
      check(N'(v), trail, ones, ref_count(N'(v), trail, ones), req);
  endtask

  task automatic t_edges();
    for (int i = 0; i < N; i++) begin
      check(N'(1) << i, 0, 0, N - 1 - i, "R3");
      check(N'(1) << i, 1, 0, i, "R3");
    end
    check('1, 0, 1, N, "R6");
    check('1, 1, 1, N, "R7");
    check('0, 1, 0, N, "R5");
  endtask

  // R8: output changes with inputs without waiting for a clock edge.
  task automatic t_comb();
    @(negedge clk);
    operand = 8'b00010000; count_trailing = 1'b0; count_ones = 1'b0;
    #1;
    n_vec++;
    if (count != 4'd3) begin
      n_bad++;
      $display("FAIL R8 actual=%0d expected=3", count);
    end
    count_trailing = 1'b1;
    #0.5;
    n_vec++;
    if (count != 4'd4) begin
      n_bad++;
      $display("FAIL R8 actual=%0d expected=4", count);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: operand zero, default mode gives N.
    @(negedge clk);
    n_vec++;
    if (count != 4'd8) begin
      n_bad++;
      $display("FAIL R2 idle actual=%0d expected=8", count);
    end
    t_width();
    t_examples();
    t_sweep(0, 0, "R2");
    t_sweep(1, 0, "R5");
    t_sweep(0, 1, "R6");
    t_sweep(1, 1, "R7");
    t_edges();
    t_comb();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule